// File: doc/BRIEF.md
# Four-Bit Arithmetic and Logic Unit with Shared Adder

This block is a purely combinational arithmetic and logic unit for two 4-bit two's-complement operands. A 4-bit operation select picks one of ten functions: addition, subtraction, bitwise inversion of the first operand, the three two-input bitwise functions, three shifts, and a pass-through of the first operand. The result is 4 bits wide. A carry output is meaningful for addition and subtraction only.

Addition and subtraction run through a single ripple adder. For subtraction, the second operand is inverted and the carry-in is forced high. One shifter serves all three shifts. In each shift the first operand is the value moved and the second operand is the distance. The distance saturates at the data width. A final multiplexer picks the result, and any select code outside the ten legal ones drives both outputs to zero. The block sits between operand registers and a result register of a surrounding datapath and holds no state of its own.

Top module: `alu4_core`

## Requirements
- R1: Select 0100 (add) gives result = (A + B) mod 16, with carry_out equal to bit 4 of the unsigned 5-bit sum.
- R2: Select 0101 (subtract) gives result = (A − B) mod 16, with carry_out equal to the raw carry of A + ~B + 1. That carry is 1 exactly when A ≥ B taken as unsigned values.
- R3: Select 1000 (invert) gives result = ~A for every value of B.
- R4: Select 1001 gives A | B, select 1010 gives A & B, and select 1011 gives A ^ B.
- R5: Select 1100 (left shift) gives A shifted left by B places with zeros entering at bit 0. A distance of 4 or more gives 0000.
- R6: Select 1101 (logical right shift) gives A shifted right by B places with zeros entering at bit 3. A distance of 4 or more gives 0000.
- R7: Select 1110 (arithmetic right shift) gives A shifted right by B places with copies of A[3] entering at bit 3. A distance of 4 or more gives four copies of A[3].
- R8: Select 1111 (copy) gives result = A.
- R9: carry_out is 0 for every legal select other than 0100 and 0101.
- R10: Select codes 0000, 0001, 0010, 0011, 0110 and 0111 drive result to 0000 and carry_out to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 4 | First operand. It is also the value that gets shifted. |
| b_in | input | 4 | Second operand. It is also the shift distance. |
| op_sel | input | 4 | Operation select code. |
| result | output | 4 | Selected result. |
| carry_out | output | 1 | Adder carry for add and subtract. It is 0 otherwise. |

## Verification
The hardest cases to reach from the ports are the saturated shift distances (5 to 15) combined with a negative first operand under the arithmetic right shift. In that corner the fill value, the sign copy and the distance clamp all interact. The other hard case is the subtraction carry at the A = B boundary and at wrap-around. Directed tasks target these cases with chosen operand pairs. A final sweep applies all 4096 combinations of operands and select codes against an integer reference model, which also reaches every illegal code with every operand pair.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'b0100,
    OP_SUB = 4'b0101,
    OP_NOT = 4'b1000,
    OP_OR  = 4'b1001,
    OP_AND = 4'b1010,
    OP_XOR = 4'b1011,
    OP_SLL = 4'b1100,
    OP_SRL = 4'b1101,
    OP_SRA = 4'b1110,
    OP_CPY = 4'b1111
  } alu_op_e;

  // Shifter and bitwise units are steered by the two low select bits.
  typedef enum logic [1:0] {
    SH_LEFT = 2'b00,
    SH_RLOG = 2'b01,
    SH_RARI = 2'b10,
    SH_PASS = 2'b11
  } sh_mode_e;

  function automatic logic op_is_arith(input logic [3:0] op);
    return op[3:1] == 3'b010;
  endfunction

  function automatic logic op_legal(input logic [3:0] op);
    return op[3] | op_is_arith(op);
  endfunction

endpackage

// File: rtl/alu4_adder.sv
module alu4_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] b_eff;
  logic [W:0]   c;

  assign b_eff = b ^ {W{sub}};
  assign c[0]  = sub;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign sum[i]   = a[i] ^ b_eff[i] ^ c[i];
      assign c[i+1]   = (a[i] & b_eff[i]) | (c[i] & (a[i] ^ b_eff[i]));
    end
  endgenerate

  assign cout = c[W];

  // Sum and difference checked through their inverse operation.
  always_comb begin
    if (sub) begin
      a_r2_sub_inverse: assert ((sum + b) == a);
    end else begin
      a_r1_add_inverse: assert ((sum - b) == a);
    end
  end
endmodule

// File: rtl/alu4_shifter.sv
module alu4_shifter
  import alu4_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   mode,
  output logic [W-1:0] res
);
  localparam int AW = $clog2(W + 1);

  logic [AW-1:0] amt;
  logic          fill;

  always_comb begin
    if (int'(b) > W) amt = AW'(W);
    else             amt = AW'(b);
  end

  assign fill = (mode == SH_RARI) & a[W-1];

  always_comb begin
    res = a;
    for (int i = 0; i < W; i++) begin
      int src;
      case (mode)
        SH_LEFT: begin
          src = i - int'(amt);
          res[i] = (src >= 0) ? a[src] : 1'b0;
        end
        SH_RLOG, SH_RARI: begin
          src = i + int'(amt);
          res[i] = (src < W) ? a[src] : fill;
        end
        default: res[i] = a[i];
      endcase
    end
  end

  always_comb begin
    if (mode == SH_RARI) begin
      a_r7_sra_keeps_sign: assert (res[W-1] == a[W-1]);
    end
    if (mode == SH_LEFT && b != '0) begin
      a_r5_sll_lsb_zero: assert (res[0] == 1'b0);
    end
    if (mode == SH_RLOG && b != '0) begin
      a_r6_srl_msb_zero: assert (res[W-1] == 1'b0);
    end
  end
endmodule

// File: rtl/alu4_bitwise.sv
module alu4_bitwise #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   fn,
  output logic [W-1:0] res
);
  always_comb begin
    case (fn)
      2'b00:   res = ~a;
      2'b01:   res = a | b;
      2'b10:   res = a & b;
      default: res = a ^ b;
    endcase
  end
endmodule

// File: rtl/alu4_core.sv
module alu4_core
  import alu4_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [3:0]   op_sel,
  output logic [W-1:0] result,
  output logic         carry_out
);
  logic         do_sub;
  logic [W-1:0] add_sum;
  logic         add_carry;
  logic [W-1:0] sh_res;
  logic [W-1:0] bw_res;

  assign do_sub = (op_sel == OP_SUB);

  alu4_adder #(.W(W)) u_adder (
    .a    (a_in),
    .b    (b_in),
    .sub  (do_sub),
    .sum  (add_sum),
    .cout (add_carry)
  );

  alu4_shifter #(.W(W)) u_shift (
    .a    (a_in),
    .b    (b_in),
    .mode (op_sel[1:0]),
    .res  (sh_res)
  );

  alu4_bitwise #(.W(W)) u_bits (
    .a   (a_in),
    .b   (b_in),
    .fn  (op_sel[1:0]),
    .res (bw_res)
  );

  always_comb begin
    result    = '0;
    carry_out = 1'b0;
    case (op_sel)
      OP_ADD, OP_SUB: begin
        result    = add_sum;
        carry_out = add_carry;
      end
      OP_NOT, OP_OR, OP_AND, OP_XOR: result = bw_res;
      OP_SLL, OP_SRL, OP_SRA:        result = sh_res;
      OP_CPY:                        result = a_in;
      default: ;
    endcase
  end

  always_comb begin
    if (!op_legal(op_sel)) begin
      a_r10_illegal_clears: assert (result == '0 && !carry_out);
    end
    if (op_sel[3]) begin
      a_r9_carry_quiet: assert (!carry_out);
    end
    if (op_sel == OP_NOT) begin
      a_r3_not_complements: assert ((result ^ a_in) == '1);
    end
  end
endmodule

// File: tb/alu4_core_test.sv
`timescale 1ns/1ps
module alu4_core_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] a, b, op;
  logic [3:0] result;
  logic       carry_out;
  int         total = 0;
  int         fails = 0;
  bit         done  = 1'b0;

  always #2.5 clk = ~clk;

  alu4_core uut (
    .a_in      (a),
    .b_in      (b),
    .op_sel    (op),
    .result    (result),
    .carry_out (carry_out)
  );

  // Integer reference model built from the requirement text.
  function automatic int model(input int av, input int bv, input int ov);
    int d, s, sa;
    d = (bv > 4) ? 4 : bv;
    sa = (av >= 8) ? av - 16 : av;
    case (ov)
      4: begin s = av + bv;            return ((s / 16) << 4) | (s % 16); end
      5: begin s = av + (15 - bv) + 1; return ((s / 16) << 4) | (s % 16); end
      8:  return 15 - av;
      9:  return av | bv;
      10: return av & bv;
      11: return av ^ bv;
      12: return (av * (1 << d)) % 16;
      13: return av / (1 << d);
      14: return (sa >>> d) & 15;
      15: return av;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input int ov);
    case (ov)
      4: return "R1";  5: return "R2";  8: return "R3";
      9, 10, 11: return "R4";
      12: return "R5"; 13: return "R6"; 14: return "R7"; 15: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input int av, input int bv, input int ov);
    @(negedge clk);
    a = 4'(av); b = 4'(bv); op = 4'(ov);
    #1;
  endtask

  task automatic check(input string tag, input int av, input int bv, input int ov);
    int exp, got;
    apply(av, bv, ov);
    exp = model(av, bv, ov);
    got = {27'd0, carry_out, result};
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s a=%0d b=%0d op=%b actual=%b expected=%b",
               tag, av, bv, 4'(ov), 5'(got), 5'(exp));
    end
  endtask

  task automatic t_reset_state;
    int got;
    apply(0, 0, 0);
    got = {27'd0, carry_out, result};
    total++;
    if (got != 0) begin
      fails++;
      $display("FAIL R10 idle after reset actual=%b expected=00000", 5'(got));
    end
  endtask

  task automatic t_add;
    check("R1", 7, 1, 4); check("R1", 15, 1, 4); check("R1", 8, 8, 4);
  endtask

  task automatic t_sub;
    check("R2", 5, 5, 5); check("R2", 3, 4, 5); check("R2", 0, 15, 5); check("R2", 9, 2, 5);
  endtask

  task automatic t_not;  // R3: B must have no effect
    for (int bv = 0; bv < 16; bv++) check("R3", 6, bv, 8);
  endtask

  task automatic t_bitwise;
    check("R4", 12, 10, 9); check("R4", 12, 10, 10); check("R4", 12, 10, 11);
  endtask

  task automatic t_shifts;
    check("R5", 3, 1, 12); check("R5", 15, 4, 12); check("R5", 15, 9, 12);
    check("R6", 8, 3, 13); check("R6", 15, 15, 13);
    check("R7", 9, 1, 14); check("R7", 8, 4, 14); check("R7", 10, 13, 14);
    check("R7", 7, 6, 14);
  endtask

  task automatic t_copy_and_carry;
    check("R8", 13, 2, 15);
    for (int ov = 8; ov < 16; ov++) check("R9", 15, 15, ov);
  endtask

  task automatic t_illegal;
    for (int ov = 0; ov < 8; ov++)
      if (ov != 4 && ov != 5) check("R10", 15, 15, ov);
  endtask

  task automatic t_sweep;
    for (int ov = 0; ov < 16; ov++)
      for (int av = 0; av < 16; av++)
        for (int bv = 0; bv < 16; bv++)
          check(tag_of(ov), av, bv, ov);
  endtask

  initial begin
    a = '0; b = '0; op = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_add();
    t_sub();
    t_not();
    t_bitwise();
    t_shifts();
    t_copy_and_carry();
    t_illegal();
    t_sweep();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule